// File: doc/BRIEF.md
# GPIO Edge Interrupt Status Controller

This block turns a bank of general-purpose input pins into two interrupt lines. Each pin passes through a synchroniser and an edge detector. Per-pin enable and polarity bits choose which edges count. The edge that matches a pin's polarity is latched as an "assert" event. The opposite edge is latched in a separate "deassert" status register. Each status register drives its own interrupt output. To watch both edges of a pin, software sets the pin's polarity to 1 and services both interrupt lines: rising edges land in the assert status and falling edges in the deassert status.

The two status registers are 32 bits wide. Bit 0 is not a status bit: on a write it selects the write mode, and on a read it returns 0. Status bit k+1 belongs to pin k. A write with bit 0 low clears every status bit whose data bit is 1. A write with bit 0 high sets every status bit whose data bit is 1. Software therefore acknowledges or injects any group of events with one write and never needs a read-modify-write. Registers are reached through a plain write port and a combinational read port, each with a two-bit register select.

Top module: `gpei_ctrl`

## Requirements
- R1: After reset the enable, polarity, assert-status and deassert-status registers all read 0, and both interrupt outputs are low.
- R2: Register select codes are 0 = enable, 1 = polarity, 2 = assert status, 3 = deassert status. A write to code 0 or 1 stores wr_data bit k as the setting of pin k. Reading either register returns the stored bits, with 0 above bit NUM_PINS-1.
- R3: With polarity bit 1 on an enabled pin k, a rising edge sets assert-status bit k+1 and a falling edge sets deassert-status bit k+1.
- R4: With polarity bit 0 on an enabled pin k, a falling edge sets assert-status bit k+1 and a rising edge sets deassert-status bit k+1.
- R5: A pin whose enable bit is 0 sets no status bit. Clearing an enable bit leaves status bits that the pin has already latched unchanged.
- R6: A status write with wr_data bit 0 = 0 clears each status bit k+1 whose wr_data bit k+1 is 1, and leaves all other status bits unchanged.
- R7: A status write with wr_data bit 0 = 1 sets each status bit k+1 whose wr_data bit k+1 is 1, and leaves all other status bits unchanged.
- R8: Status bit 0 and status bits above NUM_PINS always read 0. Each interrupt output is high exactly when any status bit of its own register is set.
- R9: If an edge event and a clearing write for the same status bit fall in the same clock cycle, the bit ends up set.
- R10: With SYNC_STAGES = 2, a pin level first sampled at rising clock edge n is visible in the status register after rising edge n+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 32 | Read data of the selected register |
| irq_assert | output | 1 | OR of the assert-status bits |
| irq_deassert | output | 1 | OR of the deassert-status bits |

## Verification
The bench targets the same-cycle collision between a clearing write and a new edge. A design that lets the write win would lose that interrupt. The bench also checks exact synchroniser latency, where an extra or missing stage moves the status update by one cycle. It checks that the write-mode bit really selects set against clear: a swapped decode would clear bits that software meant to inject. Other checks cover the one-bit shift between pin index and status bit, where an off-by-one design would light the wrong bit or show a value in bit 0, and status retention when a pin is disabled, where a design that clears on disable would drop pending events.

// File: rtl/gpei_pkg.sv
package gpei_pkg;
   localparam int MAX_PINS = 31;
   localparam int REG_W    = 32;

   typedef enum logic [1:0] {
      SEL_ENABLE        = 2'd0,
      SEL_POLARITY      = 2'd1,
      SEL_STAT_ASSERT   = 2'd2,
      SEL_STAT_DEASSERT = 2'd3
   } gpei_sel_e;

   // place pin-indexed status bits above the write-mode position
   function automatic logic [REG_W-1:0] pack_status(input logic [MAX_PINS-1:0] stat);
      return {stat, 1'b0};
   endfunction

   // place pin-indexed configuration bits starting at bit 0
   function automatic logic [REG_W-1:0] pack_cfg(input logic [MAX_PINS-1:0] cfg);
      return {1'b0, cfg};
   endfunction
endpackage

// File: rtl/gpei_sync.sv
module gpei_sync #(
   parameter int WIDTH       = 31,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   logic [SYNC_STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d_in;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign d_out = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/gpei_edge.sv
module gpei_edge #(
   parameter int WIDTH = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] enable,
   input  logic [WIDTH-1:0] polarity,
   output logic [WIDTH-1:0] evt_match,
   output logic [WIDTH-1:0] evt_opp
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] rise;
   logic [WIDTH-1:0] fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;

   for (genvar k = 0; k < WIDTH; k++) begin : g_pin
      always_comb begin
         if (polarity[k]) begin
            evt_match[k] = enable[k] & rise[k];
            evt_opp[k]   = enable[k] & fall[k];
         end else begin
            evt_match[k] = enable[k] & fall[k];
            evt_opp[k]   = enable[k] & rise[k];
         end
      end
   end
endmodule

// File: rtl/gpei_status.sv
module gpei_status #(
   parameter int WIDTH = 31,
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic             wr_hit,
   input  logic [REG_W-1:0] wr_data,
   output logic [WIDTH-1:0] stat,
   output logic             irq
);
   logic [WIDTH-1:0] stat_q;
   logic [WIDTH-1:0] stat_d;
   logic [WIDTH-1:0] wr_mask;
   logic             set_mode;

   assign wr_mask  = wr_data[WIDTH:1];
   assign set_mode = wr_data[0];

   always_comb begin
      stat_d = stat_q;
      if (wr_hit) begin
         if (set_mode) stat_d = stat_q | wr_mask;
         else          stat_d = stat_q & ~wr_mask;
      end
      // a fresh event overrides a clear in the same cycle
      stat_d = stat_d | evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assign stat = stat_q;
   assign irq  = |stat_q;
endmodule

// File: rtl/gpei_ctrl.sv
module gpei_ctrl
   import gpei_pkg::*;
#(
   parameter int NUM_PINS    = 31,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [31:0]         wr_data,
   input  logic [1:0]          rd_sel,
   output logic [31:0]         rd_data,
   output logic                irq_assert,
   output logic                irq_deassert
);
   localparam int PAD = MAX_PINS - NUM_PINS;

   initial begin : p_param_chk
      assert (NUM_PINS >= 1 && NUM_PINS <= MAX_PINS)
         else $fatal(1, "NUM_PINS must lie in 1..%0d", MAX_PINS);
      assert (SYNC_STAGES >= 2)
         else $fatal(1, "SYNC_STAGES must be at least 2");
   end

   gpei_sel_e wsel;
   gpei_sel_e rsel;
   assign wsel = gpei_sel_e'(wr_sel);
   assign rsel = gpei_sel_e'(rd_sel);

   logic [NUM_PINS-1:0] en_q;
   logic [NUM_PINS-1:0] pol_q;
   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] evt_a;
   logic [NUM_PINS-1:0] evt_d;
   logic [NUM_PINS-1:0] stat_a;
   logic [NUM_PINS-1:0] stat_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pol_q <= '0;
      end else if (wr_en) begin
         if (wsel == SEL_ENABLE)   en_q  <= wr_data[NUM_PINS-1:0];
         if (wsel == SEL_POLARITY) pol_q <= wr_data[NUM_PINS-1:0];
      end
   end

   gpei_sync #(.WIDTH(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .d_out (pin_sync)
   );

   gpei_edge #(.WIDTH(NUM_PINS)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .level     (pin_sync),
      .enable    (en_q),
      .polarity  (pol_q),
      .evt_match (evt_a),
      .evt_opp   (evt_d)
   );

   gpei_status #(.WIDTH(NUM_PINS), .REG_W(REG_W)) u_stat_assert (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_a),
      .wr_hit  (wr_en && (wsel == SEL_STAT_ASSERT)),
      .wr_data (wr_data),
      .stat    (stat_a),
      .irq     (irq_assert)
   );

   gpei_status #(.WIDTH(NUM_PINS), .REG_W(REG_W)) u_stat_deassert (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_d),
      .wr_hit  (wr_en && (wsel == SEL_STAT_DEASSERT)),
      .wr_data (wr_data),
      .stat    (stat_d),
      .irq     (irq_deassert)
   );

   // widen pin vectors to the full register width
   logic [MAX_PINS-1:0] en_w, pol_w, stat_a_w, stat_d_w;
   if (PAD > 0) begin : g_pad
      assign en_w     = {{PAD{1'b0}}, en_q};
      assign pol_w    = {{PAD{1'b0}}, pol_q};
      assign stat_a_w = {{PAD{1'b0}}, stat_a};
      assign stat_d_w = {{PAD{1'b0}}, stat_d};
   end else begin : g_full
      assign en_w     = en_q;
      assign pol_w    = pol_q;
      assign stat_a_w = stat_a;
      assign stat_d_w = stat_d;
   end

   always_comb begin
      unique case (rsel)
         SEL_ENABLE:      rd_data = pack_cfg(en_w);
         SEL_POLARITY:    rd_data = pack_cfg(pol_w);
         SEL_STAT_ASSERT: rd_data = pack_status(stat_a_w);
         default:         rd_data = pack_status(stat_d_w);
      endcase
   end
endmodule

// File: rtl/gpei_ctrl_chk.sv
module gpei_ctrl_chk
   import gpei_pkg::*;
#(
   parameter int NUM_PINS = 31
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [1:0]          wr_sel,
   input logic [31:0]         wr_data,
   input logic [1:0]          rd_sel,
   input logic [31:0]         rd_data,
   input logic                irq_assert,
   input logic                irq_deassert,
   input logic [NUM_PINS-1:0] en_q,
   input logic [NUM_PINS-1:0] evt_a,
   input logic [NUM_PINS-1:0] evt_d,
   input logic [NUM_PINS-1:0] stat_a,
   input logic [NUM_PINS-1:0] stat_d
);
   AST_STAT_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel[1] |-> !rd_data[0]); // R8
   AST_IRQA_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 2'd2) |-> (irq_assert == (|rd_data))); // R8
   AST_IRQD_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 2'd3) |-> (irq_deassert == (|rd_data))); // R8

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      AST_GATED_EVT: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q[k] |-> !(evt_a[k] || evt_d[k])); // R5
      AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         !(evt_a[k] && evt_d[k])); // R3
      AST_EVT_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
         evt_a[k] |=> stat_a[k]); // R9
      AST_EVT_WINS_D: assert property (@(posedge clk) disable iff (!rst_n)
         evt_d[k] |=> stat_d[k]); // R9
      AST_CLR_A: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_sel == 2'd2 && !wr_data[0] && wr_data[k+1] && !evt_a[k])
         |=> !stat_a[k]); // R6
      AST_SET_D: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_sel == 2'd3 && wr_data[0] && wr_data[k+1]) |=> stat_d[k]); // R7
      AST_RISE_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_a[k]) |->
            $past(evt_a[k] || (wr_en && wr_sel == 2'd2 && wr_data[0] && wr_data[k+1]))); // R7
   end
endmodule

bind gpei_ctrl gpei_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .wr_data      (wr_data),
   .rd_sel       (rd_sel),
   .rd_data      (rd_data),
   .irq_assert   (irq_assert),
   .irq_deassert (irq_deassert),
   .en_q         (en_q),
   .evt_a        (evt_a),
   .evt_d        (evt_d),
   .stat_a       (stat_a),
   .stat_d       (stat_d)
);

// File: tb/gpei_ctrl_tb.sv
module gpei_ctrl_tb_top;
   localparam int NP = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_in = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd0;
   logic [31:0]   wr_data = '0;
   logic [1:0]    rd_sel = 2'd0;
   logic [31:0]   rd_data;
   logic          irq_assert, irq_deassert;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state
   logic [NP-1:0] en_m = '0, pol_m = '0, sa_m = '0, sd_m = '0, pins_m = '0;

   always #5 clk = ~clk;

   gpei_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .irq_assert(irq_assert), .irq_deassert(irq_deassert)
   );

   function automatic logic [31:0] cfg_word(input logic [NP-1:0] v);
      return 32'(v);
   endfunction

   function automatic logic [31:0] stat_word(input logic [NP-1:0] v);
      return 32'(v) << 1;
   endfunction

   // events for an enabled pin: matching edge per polarity, opposite edge separately
   function automatic logic [NP-1:0] match_evt(input logic [NP-1:0] o, input logic [NP-1:0] n);
      return en_m & ((pol_m & n & ~o) | (~pol_m & o & ~n));
   endfunction

   function automatic logic [NP-1:0] opp_evt(input logic [NP-1:0] o, input logic [NP-1:0] n);
      return en_m & ((pol_m & o & ~n) | (~pol_m & n & ~o));
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] s, output logic [31:0] d);
      rd_sel = s;
      #1;
      d = rd_data;
   endtask

   task automatic check_all(input string req);
      logic [31:0] d;
      rd(2'd0, d); check({req, " enable"}, d, cfg_word(en_m));
      rd(2'd1, d); check({req, " polarity"}, d, cfg_word(pol_m));
      rd(2'd2, d); check({req, " assert status"}, d, stat_word(sa_m));
      rd(2'd3, d); check({req, " deassert status"}, d, stat_word(sd_m));
      check({req, " irq_assert"}, 32'(irq_assert), 32'(|sa_m));
      check({req, " irq_deassert"}, 32'(irq_deassert), 32'(|sd_m));
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (s)
         2'd0: en_m = d[NP-1:0];
         2'd1: pol_m = d[NP-1:0];
         2'd2: sa_m = d[0] ? (sa_m | d[NP:1]) : (sa_m & ~d[NP:1]);
         default: sd_m = d[0] ? (sd_m | d[NP:1]) : (sd_m & ~d[NP:1]);
      endcase
   endtask

   task automatic pins(input logic [NP-1:0] n);
      @(negedge clk);
      pin_in = n;
      repeat (4) @(negedge clk);
      sa_m = sa_m | match_evt(pins_m, n);
      sd_m = sd_m | opp_evt(pins_m, n);
      pins_m = n;
   endtask

   initial begin : p_watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : p_main
      logic [31:0] d;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");

      // R2: unused bits are dropped
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); check("R2 enable mask", d, 32'h00FF_FFFF);
      wr(2'd1, 32'hA5A5_5A5A);
      check_all("R2 polarity store");
      wr(2'd1, 32'h0000_00FF);

      // R3: polarity 1 on pin 2, R4: polarity 0 on pin 9
      pins(24'h000004); check_all("R3 rise to assert");
      pins(24'h000000); check_all("R3 fall to deassert");
      pins(24'h000200); check_all("R4 rise to deassert");
      pins(24'h000000); check_all("R4 fall to assert");
      rd(2'd2, d); check("R8 pin9 maps to bit10", d & 32'h0000_0400, 32'h0000_0400);

      // R6 clear selected bits, R7 set selected bits
      wr(2'd2, 32'h0000_0008);
      check_all("R6 clear keeps others");
      wr(2'd3, 32'hFFFF_FFFF);
      check_all("R7 set all");
      rd(2'd3, d); check("R8 top bits zero", d, 32'h01FF_FFFE);
      wr(2'd3, 32'hFFFF_FFFE);
      wr(2'd2, 32'hFFFF_FFFE);
      check_all("R6 clear all");

      // R5: latched status survives disable; disabled pin is ignored
      wr(2'd1, 32'h0000_0020);
      pins(24'h000020);
      wr(2'd0, 32'h00FF_FFDF);
      check_all("R5 retain after disable");
      pins(24'h000000);
      pins(24'h000020);
      check_all("R5 disabled pin ignored");
      wr(2'd0, 32'h00FF_FFFF);
      wr(2'd2, 32'hFFFF_FFFE);

      // R10 latency and R9 collision on pin 3 (polarity 1)
      wr(2'd1, 32'h0000_0008);
      @(negedge clk);
      pin_in = 24'h000028;
      @(posedge clk); @(negedge clk);
      rd(2'd2, d); check("R10 not after first edge", d, 32'h0);
      @(posedge clk); @(negedge clk);
      rd(2'd2, d); check("R10 not after second edge", d, 32'h0);
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h0000_0010;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      rd(2'd2, d); check("R9 R10 event beats clear", d, 32'h0000_0010);
      check("R9 irq_assert", 32'(irq_assert), 32'd1);
      sa_m = 24'h000008;
      pins_m = 24'h000028;
      repeat (3) @(negedge clk);
      check_all("R9 settle");

      // random mix
      for (int i = 0; i < 200; i++) begin
         if ($urandom_range(0, 1) == 0)
            pins(NP'($urandom()));
         else
            wr(2'($urandom_range(0, 3)), $urandom());
         check_all("R3 R4 R5 R6 R7 R8 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule